// File: doc/BRIEF.md
# Synthesizer Power-Up Programming Sequencer

This block programs a serially configured frequency synthesizer after power is first applied. A single start pulse captures three 24-bit configuration words: the reference-divider word, the control word and the feedback (N) divider word. The block then sends them over a three-wire link made of a serial clock, serial data and latch enable. The order is fixed: reference word first, then control word, then N word. Each word is committed to the device by a latch-enable pulse that follows its last bit.

The control word powers up the synthesizer's oscillator, and its bias currents need time to settle before the N word starts band selection. The sequencer therefore holds a minimum settle gap between committing the control word and committing the N word. An interval-select input picks one of two gaps. The long gap (5 ms by default) suits the large noise-filter capacitor. The short gap (600 µs by default) suits the small capacitor. The block converts both gaps to system-clock cycles from a clock-frequency parameter. The reference and control words follow each other with only a one-bit-period idle between them.

Top module: `synth_pwrup_seq`

## Requirements
- R1: While reset is asserted and whenever the block is idle, `sclk_o`, `sdata_o`, `le_o`, `busy_o` and `done_o` are all low.
- R2: A start pulse while idle captures the three words and the interval select. The block then sends exactly three words in the order reference, control, N. Each word is 24 bits, most significant bit first.
- R3: `sdata_o` changes only while `sclk_o` is low, so it is stable through every high phase of the serial clock, where the device samples it on the rising edge.
- R4: `le_o` stays low while bits are shifted. After the last bit it is high for exactly one serial bit period (2·SCLK_HALF system cycles), and `sclk_o` is never high at the same time as `le_o`.
- R5: With `wait_long_i`=1 at start, the gap from the rising edge of the control word's latch pulse to the rising edge of the N word's latch pulse is at least LONG_US microseconds of system-clock cycles.
- R6: With `wait_long_i`=0 at start, that same gap is at least SHORT_US microseconds of cycles and no more than one word transfer plus a few cycles beyond it.
- R7: No settle gap is inserted between the reference and control words. Their latch pulses rise (2·24+4)·SCLK_HALF to (2·24+4)·SCLK_HALF+8 cycles apart, which includes a one-bit-period idle after each latch pulse.
- R8: `done_o` is high for exactly one cycle after the N word has been latched. `busy_o` is already low in that cycle.
- R9: A start pulse while `busy_o` is high is ignored. No extra word is sent, and changes to the word inputs or `wait_long_i` during the sequence do not alter the words sent or the gap used.
- R10: Each serial bit period is exactly 2·SCLK_HALF system cycles, with SCLK_HALF cycles low followed by SCLK_HALF cycles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin the power-up sequence |
| wait_long_i | input | 1 | Settle-gap select: 1 = long gap, 0 = short gap |
| r_word_i | input | 24 | Reference-divider configuration word |
| ctrl_word_i | input | 24 | Control configuration word |
| n_word_i | input | 24 | N-divider configuration word |
| sclk_o | output | 1 | Serial clock to the synthesizer |
| sdata_o | output | 1 | Serial data, changed while the clock is low |
| le_o | output | 1 | Latch enable, pulsed high to commit a word |
| busy_o | output | 1 | High from start until the N word is committed |
| done_o | output | 1 | One-cycle pulse when the sequence completes |

## Verification
A wrong shift count or a bad bit pointer shows up as a wrong captured word or a wrong bit count at the next latch-enable pulse, within one word time. A state machine that skips or repeats a state changes the number of latch pulses, or the spacing between them. A settle counter that is loaded wrongly or wraps shows up as a control-to-N spacing outside the expected window, and the bench measures that spacing directly for both selections. Faults in the serial clock divider alter the measured bit period, or move data while the clock is high, and this is seen on the very next bit.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_R_GO,
    ST_R_WAIT,
    ST_C_GO,
    ST_C_WAIT,
    ST_SETTLE,
    ST_N_GO,
    ST_N_WAIT
  } seq_st_e;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_SHIFT,
    SH_LATCH,
    SH_TAIL
  } sh_st_e;

  // ceiling conversion so the gap never falls short of the request
  function automatic longint unsigned us_to_cyc(longint unsigned hz, longint unsigned us);
    return (hz * us + 64'd999_999) / 64'd1_000_000;
  endfunction

endpackage

// File: rtl/sseq_tick.sv
module sseq_tick #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int unsigned LAST = HALF - 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run || cnt_q == CW'(LAST)) cnt_d = '0;
    else                            cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == CW'(LAST));

  // R10
  half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LAST));

  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/sseq_shifter.sv
module sseq_shifter
  import sseq_pkg::*;
#(
  parameter int unsigned W    = 24,
  parameter int unsigned HALF = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] word,
  output logic         sclk,
  output logic         sdata,
  output logic         le,
  output logic         done
);

  localparam int unsigned BCW = $clog2(W);

  sh_st_e         st_q, st_d;
  logic [W-1:0]   shreg_q, shreg_d;
  logic [BCW-1:0] bitc_q, bitc_d;
  logic           ph_q, ph_d;
  logic           sclk_q, sclk_d;
  logic           le_q, le_d;
  logic           done_q, done_d;
  logic           tick, run, en;

  assign run = (st_q != SH_IDLE);

  sseq_tick #(.HALF(HALF)) i_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  assign en = tick || (st_q == SH_IDLE && go);

  always_comb begin
    st_d    = st_q;
    shreg_d = shreg_q;
    bitc_d  = bitc_q;
    ph_d    = ph_q;
    sclk_d  = sclk_q;
    le_d    = le_q;
    done_d  = 1'b0;
    case (st_q)
      SH_IDLE: begin
        if (go) begin
          st_d    = SH_SHIFT;
          shreg_d = word;
          bitc_d  = '0;
          ph_d    = 1'b0;
          sclk_d  = 1'b0;
          le_d    = 1'b0;
        end
      end
      SH_SHIFT: begin
        if (tick) begin
          if (!ph_q) begin
            sclk_d = 1'b1;
            ph_d   = 1'b1;
          end else begin
            sclk_d = 1'b0;
            ph_d   = 1'b0;
            if (bitc_q == BCW'(W - 1)) begin
              shreg_d = '0;
              bitc_d  = '0;
              le_d    = 1'b1;
              st_d    = SH_LATCH;
            end else begin
              shreg_d = shreg_q << 1;
              bitc_d  = bitc_q + BCW'(1);
            end
          end
        end
      end
      SH_LATCH: begin
        if (tick) begin
          if (!ph_q) begin
            ph_d = 1'b1;
          end else begin
            ph_d = 1'b0;
            le_d = 1'b0;
            st_d = SH_TAIL;
          end
        end
      end
      SH_TAIL: begin
        if (tick) begin
          if (!ph_q) begin
            ph_d = 1'b1;
          end else begin
            ph_d   = 1'b0;
            st_d   = SH_IDLE;
            done_d = 1'b1;
          end
        end
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SH_IDLE;
      shreg_q <= '0;
      bitc_q  <= '0;
      ph_q    <= 1'b0;
      sclk_q  <= 1'b0;
      le_q    <= 1'b0;
    end else if (en) begin
      st_q    <= st_d;
      shreg_q <= shreg_d;
      bitc_q  <= bitc_d;
      ph_q    <= ph_d;
      sclk_q  <= sclk_d;
      le_q    <= le_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign sclk  = sclk_q;
  assign sdata = shreg_q[W-1];
  assign le    = le_q;
  assign done  = done_q;

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(shreg_q[W-1]));

  // R4
  le_sclk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(le_q && sclk_q));

  // R4
  le_data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_q |-> !shreg_q[W-1]);

  // R8
  shift_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/sseq_settle.sv
module sseq_settle #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          en;

  assign en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R5
  settle_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> cnt_q == '0);

  // R6
  settle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));

endmodule

// File: rtl/synth_pwrup_seq.sv
module synth_pwrup_seq
  import sseq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned WORD_W    = 24,
  parameter int unsigned SCLK_HALF = 4,
  parameter int unsigned LONG_US   = 5000,
  parameter int unsigned SHORT_US  = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wait_long_i,
  input  logic [WORD_W-1:0] r_word_i,
  input  logic [WORD_W-1:0] ctrl_word_i,
  input  logic [WORD_W-1:0] n_word_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              le_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam longint unsigned LONG_RAW  = us_to_cyc(longint'(CLK_HZ), longint'(LONG_US));
  localparam longint unsigned SHORT_RAW = us_to_cyc(longint'(CLK_HZ), longint'(SHORT_US));
  localparam int unsigned LONG_CYC  = (LONG_RAW  > 0) ? int'(LONG_RAW)  : 1;
  localparam int unsigned SHORT_CYC = (SHORT_RAW > 0) ? int'(SHORT_RAW) : 1;
  localparam int unsigned MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned TW        = $clog2(MAX_CYC + 1);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  seq_st_e           st_q, st_d;
  logic [WORD_W-1:0] r_q, c_q, n_q;
  logic              long_q;
  logic              done_q, done_d;
  logic              cap_en;
  logic              sh_go, sh_done;
  logic [WORD_W-1:0] sh_word;
  logic              tmr_load, tmr_expired;
  logic [TW-1:0]     tmr_val;
  logic              sclk_w, le_w, sdata_w;

  assign cap_en = (st_q == ST_IDLE) && start_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (start_i)     st_d = ST_R_GO;
      ST_R_GO:                    st_d = ST_R_WAIT;
      ST_R_WAIT: if (sh_done)     st_d = ST_C_GO;
      ST_C_GO:                    st_d = ST_C_WAIT;
      ST_C_WAIT: if (sh_done)     st_d = ST_SETTLE;
      ST_SETTLE: if (tmr_expired) st_d = ST_N_GO;
      ST_N_GO:                    st_d = ST_N_WAIT;
      ST_N_WAIT: if (sh_done)     st_d = ST_IDLE;
      default:                    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      r_q    <= '0;
      c_q    <= '0;
      n_q    <= '0;
      long_q <= 1'b0;
    end else if (cap_en) begin
      r_q    <= r_word_i;
      c_q    <= ctrl_word_i;
      n_q    <= n_word_i;
      long_q <= wait_long_i;
    end
  end

  assign done_d = (st_q == ST_N_WAIT) && sh_done;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  assign sh_go = (st_q == ST_R_GO) || (st_q == ST_C_GO) || (st_q == ST_N_GO);

  always_comb begin
    case (st_q)
      ST_C_GO: sh_word = c_q;
      ST_N_GO: sh_word = n_q;
      default: sh_word = r_q;
    endcase
  end

  sseq_shifter #(.W(WORD_W), .HALF(SCLK_HALF)) i_shifter (
    .clk  (clk),
    .rst_n(rst_ns),
    .go   (sh_go),
    .word (sh_word),
    .sclk (sclk_w),
    .sdata(sdata_w),
    .le   (le_w),
    .done (sh_done)
  );

  assign tmr_load = (st_q == ST_C_WAIT) && sh_done;
  assign tmr_val  = long_q ? TW'(LONG_CYC) : TW'(SHORT_CYC);

  sseq_settle #(.TW(TW)) i_settle (
    .clk     (clk),
    .rst_n   (rst_ns),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  assign sclk_o  = sclk_w;
  assign sdata_o = sdata_w;
  assign le_o    = le_w;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !busy_o |-> (!sclk_w && !le_w && !sdata_w));

  // R5
  settle_gate_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == ST_N_GO) |-> tmr_expired);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    done_q |=> !done_q);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    done_q |-> !busy_o);

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy_o && start_i) |=> ($stable(r_q) && $stable(c_q) && $stable(n_q) && $stable(long_q)));

endmodule

// File: tb/test_synth_pwrup_seq.sv
module test_synth_pwrup_seq;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 24;
  localparam int HALF       = 2;
  localparam int HZ         = 1_000_000;
  localparam int LONG_US    = 5000;
  localparam int SHORT_US   = 600;
  localparam int LONG_CYC   = 5000;
  localparam int SHORT_CYC  = 600;
  localparam int BITP       = 2 * HALF;
  localparam int WORD_SPAN  = (2 * W + 4) * HALF;
  localparam int WD_CYCLES  = 150_000;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic         wait_long_i;
  logic [W-1:0] r_word_i, ctrl_word_i, n_word_i;
  logic         sclk_o, sdata_o, le_o, busy_o, done_o;

  synth_pwrup_seq #(
    .CLK_HZ(HZ), .WORD_W(W), .SCLK_HALF(HALF), .LONG_US(LONG_US), .SHORT_US(SHORT_US)
  ) i_synth_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wait_long_i(wait_long_i),
    .r_word_i(r_word_i), .ctrl_word_i(ctrl_word_i), .n_word_i(n_word_i),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .le_o(le_o), .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0;
  int fails  = 0;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
    $finish;
  end

  // ---------------- port monitor (samples on falling edge) ----------------
  logic         mon_clr = 1'b0;
  logic [W-1:0] cap_word [8];
  int           cap_bits [8];
  int           le_rise  [8];
  int           le_wid   [8];
  int           wcnt, nb, cyc, last_rise, le_start;
  int           per_min, per_max, sdata_bad, le_sclk_bad;
  int           done_cnt, done_run, done_wmax, done_busy_bad;
  logic [W-1:0] shv;
  logic         p_sclk = 1'b0, p_sdata = 1'b0, p_le = 1'b0;

  initial cyc = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mon_clr) begin
      wcnt = 0; nb = 0; shv = '0; last_rise = 0; le_start = 0;
      per_min = 1 << 30; per_max = 0; sdata_bad = 0; le_sclk_bad = 0;
      done_cnt = 0; done_run = 0; done_wmax = 0; done_busy_bad = 0;
      for (int k = 0; k < 8; k++) begin
        cap_word[k] = '0; cap_bits[k] = 0; le_rise[k] = 0; le_wid[k] = 0;
      end
    end else begin
      if (sclk_o && !p_sclk && !le_o) begin
        shv = {shv[W-2:0], sdata_o};
        nb  = nb + 1;
        if (nb > 1) begin
          if (cyc - last_rise < per_min) per_min = cyc - last_rise;
          if (cyc - last_rise > per_max) per_max = cyc - last_rise;
        end
        last_rise = cyc;
      end
      if (p_sclk && sclk_o && (sdata_o != p_sdata)) sdata_bad = sdata_bad + 1;
      if (le_o && sclk_o) le_sclk_bad = le_sclk_bad + 1;
      if (le_o && !p_le) begin
        if (wcnt < 8) begin
          cap_word[wcnt] = shv; cap_bits[wcnt] = nb; le_rise[wcnt] = cyc;
        end
        le_start = cyc; nb = 0; wcnt = wcnt + 1;
      end
      if (!le_o && p_le && wcnt > 0 && wcnt <= 8) le_wid[wcnt-1] = cyc - le_start;
      if (done_o) begin
        done_run = done_run + 1;
        if (busy_o) done_busy_bad = done_busy_bad + 1;
      end else if (done_run > 0) begin
        if (done_run > done_wmax) done_wmax = done_run;
        done_cnt = done_cnt + 1;
        done_run = 0;
      end
    end
    p_sclk  = sclk_o;
    p_sdata = sdata_o;
    p_le    = le_o;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk) mon_clr = 1'b1;
    @(posedge clk);
    @(posedge clk);
    mon_clr = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; wait_long_i = 1'b0;
    r_word_i = '0; ctrl_word_i = '0; n_word_i = '0;
    repeat (3) @(negedge clk);
    chk({sclk_o, sdata_o, le_o, busy_o, done_o} == 5'b0, "R1", "outputs in reset",
        {sclk_o, sdata_o, le_o, busy_o, done_o}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({sclk_o, sdata_o, le_o, busy_o, done_o} == 5'b0, "R1", "outputs idle after reset",
        {sclk_o, sdata_o, le_o, busy_o, done_o}, 0);
  endtask

  task automatic t_sequence(input logic [W-1:0] rw, input logic [W-1:0] cw,
                            input logic [W-1:0] nw, input bit lng, input bit poke);
    int gap_lo;
    int gap;
    int i;
    clear_mon();
    @(negedge clk);
    r_word_i = rw; ctrl_word_i = cw; n_word_i = nw; wait_long_i = lng; start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      r_word_i = ~rw; ctrl_word_i = ~cw; n_word_i = ~nw; wait_long_i = ~lng;
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      repeat (20) @(negedge clk);
      chk(busy_o == 1'b1, "R9", "busy after ignored start", busy_o, 1);
    end
    for (i = 0; i < 20000 && done_cnt == 0; i++) @(posedge clk);
    chk(done_cnt > 0, "R8", "sequence completion", done_cnt, 1);
    repeat (12) @(posedge clk);
    // R2 / R9: three words, right order, right values
    chk(wcnt == 3, "R2", "latch pulse count", wcnt, 3);
    chk(cap_word[0] == rw, "R2", "reference word", cap_word[0], rw);
    chk(cap_word[1] == cw, "R2", "control word", cap_word[1], cw);
    chk(cap_word[2] == nw, "R2", "N word", cap_word[2], nw);
    for (int k = 0; k < 3; k++)
      chk(cap_bits[k] == W, "R2", "bits per word", cap_bits[k], W);
    // R3 / R4 / R10: serial timing
    chk(sdata_bad == 0, "R3", "data moves while clock high", sdata_bad, 0);
    chk(le_sclk_bad == 0, "R4", "clock high during latch", le_sclk_bad, 0);
    for (int k = 0; k < 3; k++)
      chk(le_wid[k] == BITP, "R4", "latch pulse width", le_wid[k], BITP);
    chk(per_min == BITP && per_max == BITP, "R10", "bit period", per_max, BITP);
    // R7: no settle between R and control
    gap = le_rise[1] - le_rise[0];
    chk(gap >= WORD_SPAN && gap <= WORD_SPAN + 8, "R7", "R-to-control spacing", gap, WORD_SPAN);
    // R5 / R6: settle gap
    gap    = le_rise[2] - le_rise[1];
    gap_lo = lng ? LONG_CYC : SHORT_CYC;
    if (lng)
      chk(gap >= gap_lo && gap <= gap_lo + WORD_SPAN + 8, "R5", "long settle gap", gap, gap_lo);
    else
      chk(gap >= gap_lo && gap <= gap_lo + WORD_SPAN + 8, "R6", "short settle gap", gap, gap_lo);
    // R8: done pulse shape
    chk(done_cnt == 1 && done_wmax == 1, "R8", "done pulse width", done_wmax, 1);
    chk(done_busy_bad == 0, "R8", "busy during done", done_busy_bad, 0);
    @(negedge clk);
    chk(busy_o == 1'b0 && le_o == 1'b0 && sclk_o == 1'b0, "R1", "idle after sequence",
        {busy_o, le_o, sclk_o}, 0);
  endtask

  initial begin
    t_reset();
    t_sequence(24'hA5C3_0F, 24'h3C_96E1, 24'h0F_F00F, 1'b1, 1'b0);
    t_sequence(24'hFFFFFF, 24'h000001, 24'h800000, 1'b0, 1'b0);
    t_sequence(24'h123456, 24'h789ABC, 24'hDEF012, 1'b1, 1'b1);
    t_sequence(24'h555555, 24'hAAAAAA, 24'h000000, 1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule